// File: doc/BRIEF.md
# Privileged Interrupt Selection Unit

This block decides, in every cycle, whether a hart should take an interrupt and which one. It stores a pending vector and an enable vector for nine maskable sources: software, timer and external for each of the user, supervisor and machine levels. It also stores one non-maskable request flag, which has its own enable input. A gating stage builds a per-source mask from the current privilege level, the three level-wide enable bits and two delegation vectors. A fixed-priority picker then chooses among the sources that are pending, enabled and unmasked.

Software updates the state in two ways. A whole-vector write port loads the pending or the enable vector. A command port posts or clears a single source, or clears every pending flag at once. The selection outputs are combinational from the stored vectors and from the live privilege, status and delegation inputs.

Top module: `irq_select_unit`

## Requirements
- R1: Reset (synchronous, active-low) clears the pending vector, the enable vector and the non-maskable pending flag.
- R2: A vector write (`vec_we`=1) loads `vec_wdata` into the pending vector (`vec_sel`=0) or the enable vector (`vec_sel`=1) at the next rising edge. Only bit positions 0,1,3,4,5,7,8,9,11 are implemented. Other positions always read 0.
- R3: `cmd_op`=1 (post) sets and `cmd_op`=2 (clear) clears the pending bit whose position is `cmd_src`. An unimplemented position or a value of 12 to 14 changes nothing. When a command and a pending-vector write occur in the same cycle, the command is applied on top of the written value.
- R4: A post or clear with `cmd_src`=15 sets or clears the non-maskable pending flag and leaves the pending vector unchanged.
- R5: `cmd_op`=3 (clear-all) zeroes the whole pending vector and the non-maskable pending flag. This overrides any pending-vector write in the same cycle.
- R6: A maskable source can win only when its pending bit, its enable bit and its mask bit are all 1.
- R7: At privilege 3 (machine), the machine sources (bits 3,7,11) are unmasked only when `mach_gie`=1. Supervisor and user sources are always masked. Delegation has no effect.
- R8: At privilege 1 (supervisor), a machine source is unmasked when its `mach_deleg` bit is 0, or when that bit is 1 and `sup_gie`=1. Supervisor sources (bits 1,5,9) are unmasked only when `sup_gie`=1. User sources are masked.
- R9: At privilege 0 (user), a machine or supervisor source is unmasked when its `sup_deleg` bit is 0, or when that bit is 1 and `usr_gie`=1. User sources (bits 0,4,8) are unmasked only when `usr_gie`=1.
- R10: Privilege value 2 masks every maskable source and drives `priv_err` high.
- R11: When the non-maskable pending flag and `nmi_en` are both 1, `take_nmi`=1 and `take_irq`=1 with `cause`=0, whatever the maskable state.
- R12: Among the eligible sources, the winner follows the order 11, 3, 7, 9, 1, 5, 8, 0, 4 (highest first). `take_irq`=1 and `cause` is the winner's position. With no winner and no non-maskable request, `take_irq`=0 and `cause`=0.
- R13: The selection outputs follow changes on privilege, status and delegation inputs in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_we | input | 1 | Whole-vector write strobe |
| vec_sel | input | 1 | 0 selects the pending vector, 1 the enable vector |
| vec_wdata | input | 12 | Vector write data |
| cmd_op | input | 2 | 0 idle, 1 post, 2 clear, 3 clear-all |
| cmd_src | input | 4 | Source position for post or clear; 15 names the non-maskable request |
| priv_mode | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mach_gie | input | 1 | Machine level-wide interrupt enable |
| sup_gie | input | 1 | Supervisor level-wide interrupt enable |
| usr_gie | input | 1 | User level-wide interrupt enable |
| mach_deleg | input | 12 | Sources handed down from machine to supervisor |
| sup_deleg | input | 12 | Sources handed down from supervisor to user |
| nmi_en | input | 1 | Enable for the non-maskable request |
| rd_pend | output | 12 | Current pending vector |
| rd_en | output | 12 | Current enable vector |
| rd_nmi_pend | output | 1 | Current non-maskable pending flag |
| take_irq | output | 1 | An interrupt (maskable or non-maskable) should be taken |
| take_nmi | output | 1 | The non-maskable request wins |
| cause | output | 4 | Position of the winning maskable source, else 0 |
| priv_err | output | 1 | Privilege input holds the reserved value 2 |

## Verification
The bench uses the default source count of twelve and a four-bit cause field. At that size, every implemented position, the unimplemented positions 2, 6 and 10, and the non-maskable tag 15 all appear on the ports. This lets the bench test the vector writes, the ignored command positions and the non-maskable path directly. The stimulus table covers every privilege value, including the reserved one. It mixes delegated and undelegated sources at each level, so each row of the gating rules and each step of the priority order is seen at least once.

// File: rtl/irq_sel_pkg.sv
// Shared constants and types for the interrupt selection unit.
// Assumes the standard twelve-position cause layout with a four-bit cause.
package irq_sel_pkg;
    localparam int NUM_SRC = 12;
    localparam int CAUSE_W = $clog2(NUM_SRC);
    localparam int NMI_TAG = (1 << CAUSE_W) - 1;
    localparam int PRIO_N  = 9;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_POST    = 2'd1,
        CMD_CLEAR   = 2'd2,
        CMD_CLR_ALL = 2'd3
    } cmd_e;

    localparam logic [NUM_SRC-1:0] MACH_SRCS = 12'h888;
    localparam logic [NUM_SRC-1:0] SUP_SRCS  = 12'h222;
    localparam logic [NUM_SRC-1:0] USR_SRCS  = 12'h111;
    localparam logic [NUM_SRC-1:0] IMPL_SRCS = MACH_SRCS | SUP_SRCS | USR_SRCS;

    // Highest priority first.
    localparam int PRIO_ORDER [PRIO_N] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};
endpackage

// File: rtl/irq_src_store.sv
// Pending/enable vectors plus the non-maskable pending flag.
// Assumes the command port is applied after a same-cycle vector write;
// clear-all overrides everything on the pending side.
module irq_src_store
    import irq_sel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vec_we,
    input  logic                vec_sel,
    input  logic [NUM_SRC-1:0]  vec_wdata,
    input  logic [1:0]          cmd_op,
    input  logic [CAUSE_W-1:0]  cmd_src,
    output logic [NUM_SRC-1:0]  pend_q,
    output logic [NUM_SRC-1:0]  en_q,
    output logic                nmi_pend_q
);
    localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

    logic [NUM_SRC-1:0] src_hot;
    logic [NUM_SRC-1:0] pend_d;
    logic [NUM_SRC-1:0] en_d;
    logic               nmi_d;
    logic               is_nmi;

    // Decode the command source into a one-hot over implemented positions.
    always_comb begin
        is_nmi  = (cmd_src == CAUSE_W'(NMI_TAG));
        src_hot = (int'(cmd_src) < NUM_SRC) ? ((ONE << cmd_src) & IMPL_SRCS) : '0;
    end

    // Next-state for pending, enable and the non-maskable flag.
    always_comb begin
        pend_d = pend_q;
        en_d   = en_q;
        nmi_d  = nmi_pend_q;
        if (vec_we && !vec_sel) pend_d = vec_wdata & IMPL_SRCS;
        if (vec_we &&  vec_sel) en_d   = vec_wdata & IMPL_SRCS;
        case (cmd_op)
            CMD_POST: begin
                pend_d = pend_d | src_hot;
                if (is_nmi) nmi_d = 1'b1;
            end
            CMD_CLEAR: begin
                pend_d = pend_d & ~src_hot;
                if (is_nmi) nmi_d = 1'b0;
            end
            CMD_CLR_ALL: begin
                pend_d = '0;
                nmi_d  = 1'b0;
            end
            default: ;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            en_q       <= '0;
            nmi_pend_q <= 1'b0;
        end else begin
            pend_q     <= pend_d;
            en_q       <= en_d;
            nmi_pend_q <= nmi_d;
        end
    end
endmodule

// File: rtl/irq_mode_mask.sv
// Per-source gate derived from privilege, level-wide enables and delegation.
// Assumes privilege encoding 0/1/3; value 2 yields no gate and an error flag.
module irq_mode_mask
    import irq_sel_pkg::*;
(
    input  logic [1:0]         priv_mode,
    input  logic               mach_gie,
    input  logic               sup_gie,
    input  logic               usr_gie,
    input  logic [NUM_SRC-1:0] mach_deleg,
    input  logic [NUM_SRC-1:0] sup_deleg,
    output logic [NUM_SRC-1:0] gate,
    output logic               priv_err
);
    // Build the gate for the current privilege level.
    always_comb begin
        gate     = '0;
        priv_err = 1'b0;
        case (priv_mode)
            PRV_MACH: begin
                gate = mach_gie ? MACH_SRCS : '0;
            end
            PRV_SUPER: begin
                gate = (MACH_SRCS & (~mach_deleg | {NUM_SRC{sup_gie}}))
                     | (sup_gie ? SUP_SRCS : '0);
            end
            PRV_USER: begin
                gate = ((MACH_SRCS | SUP_SRCS) & (~sup_deleg | {NUM_SRC{usr_gie}}))
                     | (usr_gie ? USR_SRCS : '0);
            end
            default: begin
                gate     = '0;
                priv_err = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority choice among eligible sources.
// Assumes PRIO_ORDER lists positions highest priority first.
module irq_prio_pick
    import irq_sel_pkg::*;
(
    input  logic [NUM_SRC-1:0] ready,
    output logic               found,
    output logic [CAUSE_W-1:0] pick
);
    // Walk from lowest to highest priority so the highest match wins.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = PRIO_N - 1; i >= 0; i--) begin
            if (ready[PRIO_ORDER[i]]) begin
                found = 1'b1;
                pick  = CAUSE_W'(PRIO_ORDER[i]);
            end
        end
    end
endmodule

// File: rtl/irq_select_unit.sv
// Top of the interrupt selection unit: storage, gating and priority pick.
// Assumes outputs are consumed combinationally by the trap logic.
module irq_select_unit
    import irq_sel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vec_we,
    input  logic                vec_sel,
    input  logic [NUM_SRC-1:0]  vec_wdata,
    input  logic [1:0]          cmd_op,
    input  logic [CAUSE_W-1:0]  cmd_src,
    input  logic [1:0]          priv_mode,
    input  logic                mach_gie,
    input  logic                sup_gie,
    input  logic                usr_gie,
    input  logic [NUM_SRC-1:0]  mach_deleg,
    input  logic [NUM_SRC-1:0]  sup_deleg,
    input  logic                nmi_en,
    output logic [NUM_SRC-1:0]  rd_pend,
    output logic [NUM_SRC-1:0]  rd_en,
    output logic                rd_nmi_pend,
    output logic                take_irq,
    output logic                take_nmi,
    output logic [CAUSE_W-1:0]  cause,
    output logic                priv_err
);
    logic [NUM_SRC-1:0] gate;
    logic [NUM_SRC-1:0] ready;
    logic               found;
    logic [CAUSE_W-1:0] pick;
    logic               nmi_act;

    irq_src_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .vec_we     (vec_we),
        .vec_sel    (vec_sel),
        .vec_wdata  (vec_wdata),
        .cmd_op     (cmd_op),
        .cmd_src    (cmd_src),
        .pend_q     (rd_pend),
        .en_q       (rd_en),
        .nmi_pend_q (rd_nmi_pend)
    );

    irq_mode_mask u_mask (
        .priv_mode  (priv_mode),
        .mach_gie   (mach_gie),
        .sup_gie    (sup_gie),
        .usr_gie    (usr_gie),
        .mach_deleg (mach_deleg),
        .sup_deleg  (sup_deleg),
        .gate       (gate),
        .priv_err   (priv_err)
    );

    irq_prio_pick u_pick (
        .ready (ready),
        .found (found),
        .pick  (pick)
    );

    // Combine eligibility and let the non-maskable request override.
    always_comb begin
        ready    = rd_pend & rd_en & gate;
        nmi_act  = rd_nmi_pend & nmi_en;
        take_nmi = nmi_act;
        take_irq = nmi_act | found;
        cause    = (!nmi_act && found) ? pick : '0;
    end
endmodule

// File: rtl/irq_select_unit_chk.sv
// Property checker for irq_select_unit, attached through bind.
// Assumes it observes only the top-level ports.
module irq_select_unit_chk
    import irq_sel_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cmd_op,
    input logic [CAUSE_W-1:0]  cmd_src,
    input logic [1:0]          priv_mode,
    input logic [NUM_SRC-1:0]  rd_pend,
    input logic [NUM_SRC-1:0]  rd_en,
    input logic                rd_nmi_pend,
    input logic                take_irq,
    input logic                take_nmi,
    input logic [CAUSE_W-1:0]  cause,
    input logic                priv_err
);
    logic [NUM_SRC-1:0] chk_hot;
    logic [NUM_SRC-1:0] win_bit;

    // Observer-side decode of the command target and the reported winner.
    always_comb begin
        chk_hot = (int'(cmd_src) < NUM_SRC) ? ((NUM_SRC'(1) << cmd_src) & IMPL_SRCS) : '0;
        win_bit = NUM_SRC'(1) << cause;
    end

    // R3
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd1 && chk_hot != '0) |=> ((rd_pend & $past(chk_hot)) != '0));

    // R3
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd2 && chk_hot != '0) |=> ((rd_pend & $past(chk_hot)) == '0));

    // R5
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd3) |=> (rd_pend == '0 && !rd_nmi_pend));

    // R11
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> (take_irq && cause == '0 && rd_nmi_pend));

    // R10
    rsvd_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode == 2'd2) |-> (priv_err && (take_nmi || !take_irq)));

    // R6
    winner_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !take_nmi) |-> ((rd_pend & rd_en & win_bit) != '0));

    // R7
    mach_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode == 2'd3 && take_irq && !take_nmi) |-> ((MACH_SRCS & win_bit) != '0));
endmodule

bind irq_select_unit irq_select_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_op      (cmd_op),
    .cmd_src     (cmd_src),
    .priv_mode   (priv_mode),
    .rd_pend     (rd_pend),
    .rd_en       (rd_en),
    .rd_nmi_pend (rd_nmi_pend),
    .take_irq    (take_irq),
    .take_nmi    (take_nmi),
    .cause       (cause),
    .priv_err    (priv_err)
);

// File: tb/irq_select_unit_tb.sv
module irq_select_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_we = 1'b0;
    logic        vec_sel = 1'b0;
    logic [11:0] vec_wdata = '0;
    logic [1:0]  cmd_op = 2'd0;
    logic [3:0]  cmd_src = '0;
    logic [1:0]  priv_mode = 2'd3;
    logic        mach_gie = 1'b0, sup_gie = 1'b0, usr_gie = 1'b0;
    logic [11:0] mach_deleg = '0, sup_deleg = '0;
    logic        nmi_en = 1'b0;
    logic [11:0] rd_pend, rd_en;
    logic        rd_nmi_pend, take_irq, take_nmi, priv_err;
    logic [3:0]  cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_select_unit dut_i (
        .clk(clk), .rst_n(rst_n), .vec_we(vec_we), .vec_sel(vec_sel),
        .vec_wdata(vec_wdata), .cmd_op(cmd_op), .cmd_src(cmd_src),
        .priv_mode(priv_mode), .mach_gie(mach_gie), .sup_gie(sup_gie),
        .usr_gie(usr_gie), .mach_deleg(mach_deleg), .sup_deleg(sup_deleg),
        .nmi_en(nmi_en), .rd_pend(rd_pend), .rd_en(rd_en),
        .rd_nmi_pend(rd_nmi_pend), .take_irq(take_irq), .take_nmi(take_nmi),
        .cause(cause), .priv_err(priv_err)
    );

    typedef struct packed {
        logic [11:0] pend;
        logic [11:0] en;
        logic        np;
        logic        ne;
        logic [1:0]  prv;
        logic        mie;
        logic        sie;
        logic        uie;
        logic [11:0] mdel;
        logic [11:0] sdel;
        logic        x_take;
        logic        x_nmi;
        logic [3:0]  x_cause;
        logic        x_err;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{12'hBBB,12'hBBB,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,12'h000,12'h000,1'b1,1'b0,4'd11,1'b0}, // R7 R12
        '{12'hBBB,12'hBBB,1'b0,1'b0,2'd3,1'b0,1'b1,1'b1,12'h000,12'h000,1'b0,1'b0,4'd0,1'b0},  // R7
        '{12'h222,12'hBBB,1'b0,1'b0,2'd3,1'b1,1'b1,1'b1,12'h000,12'h000,1'b0,1'b0,4'd0,1'b0},  // R7
        '{12'h088,12'hBBB,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,12'h000,12'h000,1'b1,1'b0,4'd3,1'b0},  // R12
        '{12'h080,12'h080,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,12'h000,12'h000,1'b1,1'b0,4'd7,1'b0},  // R12
        '{12'h888,12'h000,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,12'h000,12'h000,1'b0,1'b0,4'd0,1'b0},  // R6
        '{12'hBBB,12'hBBB,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,12'h000,12'h000,1'b1,1'b0,4'd11,1'b0}, // R8
        '{12'h888,12'h888,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,12'h888,12'h000,1'b0,1'b0,4'd0,1'b0},  // R8
        '{12'h888,12'h888,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,12'h888,12'h000,1'b1,1'b0,4'd11,1'b0}, // R8
        '{12'h333,12'hBBB,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,12'h000,12'h000,1'b1,1'b0,4'd9,1'b0},  // R8
        '{12'h111,12'hBBB,1'b0,1'b0,2'd1,1'b0,1'b1,1'b1,12'h000,12'h000,1'b0,1'b0,4'd0,1'b0},  // R8
        '{12'h022,12'hBBB,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,12'h000,12'h000,1'b1,1'b0,4'd1,1'b0},  // R12
        '{12'h222,12'hBBB,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h000,12'h000,1'b1,1'b0,4'd9,1'b0},  // R9
        '{12'h222,12'hBBB,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h000,12'h222,1'b0,1'b0,4'd0,1'b0},  // R9
        '{12'h222,12'hBBB,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h000,12'h200,1'b1,1'b0,4'd1,1'b0},  // R9
        '{12'h111,12'hBBB,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h000,12'h000,1'b0,1'b0,4'd0,1'b0},  // R9
        '{12'h111,12'hBBB,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,12'h000,12'h000,1'b1,1'b0,4'd8,1'b0},  // R9
        '{12'h010,12'hBBB,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,12'h000,12'h000,1'b1,1'b0,4'd4,1'b0},  // R9
        '{12'hBBB,12'hBBB,1'b0,1'b0,2'd2,1'b1,1'b1,1'b1,12'h000,12'h000,1'b0,1'b0,4'd0,1'b1},  // R10
        '{12'hBBB,12'hBBB,1'b1,1'b1,2'd3,1'b1,1'b0,1'b0,12'h000,12'h000,1'b1,1'b1,4'd0,1'b0},  // R11
        '{12'hBBB,12'hBBB,1'b1,1'b0,2'd3,1'b1,1'b0,1'b0,12'h000,12'h000,1'b1,1'b0,4'd11,1'b0}, // R11
        '{12'hBBB,12'hBBB,1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,12'h000,12'h000,1'b1,1'b1,4'd0,1'b1},  // R11 R10
        '{12'h800,12'hBBB,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,12'h800,12'h000,1'b1,1'b0,4'd11,1'b0}, // R7
        '{12'h208,12'hBBB,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,12'h000,12'h000,1'b1,1'b0,4'd3,1'b0},  // R12
        '{12'h280,12'hBBB,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,12'h000,12'h000,1'b1,1'b0,4'd7,1'b0},  // R12
        '{12'h000,12'hBBB,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,12'h000,12'h000,1'b1,1'b1,4'd0,1'b0}   // R11
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_vec(input logic sel, input logic [11:0] d);
        vec_we = 1'b1; vec_sel = sel; vec_wdata = d;
        tick();
        vec_we = 1'b0;
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [3:0] src);
        cmd_op = op; cmd_src = src;
        tick();
        cmd_op = 2'd0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            report();
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        // R1: state after reset
        #1;
        check("R1 pend after reset", 16'(rd_pend), 16'h0);
        check("R1 en after reset", 16'(rd_en), 16'h0);
        check("R1 nmi after reset", 16'(rd_nmi_pend), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R6 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < NV; i++) begin
            wr_vec(1'b0, VEC[i].pend);
            wr_vec(1'b1, VEC[i].en);
            do_cmd(VEC[i].np ? 2'd1 : 2'd2, 4'd15);
            priv_mode = VEC[i].prv; mach_gie = VEC[i].mie; sup_gie = VEC[i].sie;
            usr_gie = VEC[i].uie; mach_deleg = VEC[i].mdel; sup_deleg = VEC[i].sdel;
            nmi_en = VEC[i].ne;
            #2;
            check($sformatf("table vec %0d take", i), 16'(take_irq), 16'(VEC[i].x_take));
            check($sformatf("table vec %0d nmi", i), 16'(take_nmi), 16'(VEC[i].x_nmi));
            check($sformatf("table vec %0d cause", i), 16'(cause), 16'(VEC[i].x_cause));
            check($sformatf("table vec %0d err", i), 16'(priv_err), 16'(VEC[i].x_err));
            @(negedge clk);
        end
        nmi_en = 1'b0;
        do_cmd(2'd2, 4'd15);

        // R2: write lands on the edge; unimplemented bits read 0
        vec_we = 1'b1; vec_sel = 1'b0; vec_wdata = 12'hFFF;
        wr_vec(1'b0, 12'h000);
        vec_we = 1'b1; vec_sel = 1'b0; vec_wdata = 12'hFFF;
        #1;
        check("R2 pend before edge", 16'(rd_pend), 16'h000);
        tick(); vec_we = 1'b0; #1;
        check("R2 pend masked", 16'(rd_pend), 16'hBBB);
        wr_vec(1'b1, 12'hFFF); #1;
        check("R2 en masked", 16'(rd_en), 16'hBBB);

        // R3: single-source post and clear, ignored positions
        wr_vec(1'b0, 12'h000);
        do_cmd(2'd1, 4'd7); #1;
        check("R3 post 7", 16'(rd_pend), 16'h080);
        do_cmd(2'd1, 4'd2); #1;
        check("R3 post unimpl 2", 16'(rd_pend), 16'h080);
        do_cmd(2'd1, 4'd13); #1;
        check("R3 post 13", 16'(rd_pend), 16'h080);
        do_cmd(2'd2, 4'd7); #1;
        check("R3 clear 7", 16'(rd_pend), 16'h000);
        vec_we = 1'b1; vec_sel = 1'b0; vec_wdata = 12'h001;
        do_cmd(2'd1, 4'd8); vec_we = 1'b0; #1;
        check("R3 post over write", 16'(rd_pend), 16'h101);
        vec_we = 1'b1; vec_sel = 1'b0; vec_wdata = 12'hBBB;
        do_cmd(2'd2, 4'd11); vec_we = 1'b0; #1;
        check("R3 clear over write", 16'(rd_pend), 16'h3BB);

        // R4: tag 15 targets the non-maskable flag only
        do_cmd(2'd1, 4'd15); #1;
        check("R4 nmi post", 16'(rd_nmi_pend), 16'h1);
        check("R4 pend untouched", 16'(rd_pend), 16'h3BB);
        do_cmd(2'd2, 4'd15); #1;
        check("R4 nmi clear", 16'(rd_nmi_pend), 16'h0);

        // R5: clear-all beats a same-cycle write
        do_cmd(2'd1, 4'd15);
        vec_we = 1'b1; vec_sel = 1'b0; vec_wdata = 12'h111;
        do_cmd(2'd3, 4'd0); vec_we = 1'b0; #1;
        check("R5 pend zero", 16'(rd_pend), 16'h000);
        check("R5 nmi zero", 16'(rd_nmi_pend), 16'h0);
        check("R5 en kept", 16'(rd_en), 16'hBBB);

        // R13: status change reflected without a clock edge
        wr_vec(1'b0, 12'h800);
        priv_mode = 2'd3; mach_gie = 1'b0; #1;
        check("R13 before enable", 16'(take_irq), 16'h0);
        mach_gie = 1'b1; #1;
        check("R13 same-cycle take", 16'(take_irq), 16'h1);
        check("R13 same-cycle cause", 16'(cause), 16'd11);

        // R1: reset in mid-run
        @(negedge clk);
        do_cmd(2'd1, 4'd15);
        rst_n = 1'b0; tick(); #1;
        check("R1 mid reset pend", 16'(rd_pend), 16'h0);
        check("R1 mid reset en", 16'(rd_en), 16'h0);
        check("R1 mid reset nmi", 16'(rd_nmi_pend), 16'h0);
        rst_n = 1'b1;

        done = 1;
        report();
    end
endmodule